// File: doc/BRIEF.md
# Read Response Packet Formatter

This block turns the bytes that a peripheral returns for a read into one reverse-direction packet on a byte stream. A request gives the virtual channel, the data type, the number of read bytes and three option bits: whether the compact format may be used, whether the header ECC byte is sent, and whether the checksum footer is sent. The read bytes then arrive on a streaming input and pass to the output in order. The output is a byte stream with a valid/ready handshake and an end-of-packet marker.

The compact (short) format is used when it is allowed and the read is 1 to 7 bytes long. It carries the identifier, the data bytes and a closing ECC byte. Every other read uses the long format: identifier, a 16-bit word count, a header ECC byte, the payload and a 2-byte checksum footer. The block does not compute ECC or checksum values. It copies `ecc_i` and `csum_i` in the cycle those bytes go out, and it sends zero fillers when the matching option is off.

Top module: `rd_resp_fmt`

## Requirements
- R1: `req_ready_o` is high only when no packet is in progress. A request is taken on `req_valid_i && req_ready_o`, and `req_ready_o` stays low from the next cycle until the last byte of that packet has been transferred.
- R2: The short format is chosen exactly when `short_en_i` is 1 and `len_i` lies in 1..7. A short packet is the identifier, `len_i` payload bytes and one ECC byte, so it is `len_i`+2 bytes long.
- R3: The short identifier byte is {vc[1:0] in bits 7:6, dtype[5:3] in bits 5:3, len[2:0] in bits 2:0}. The byte count travels in the low three bits.
- R4: A long packet is the identifier {vc in bits 7:6, dtype in bits 5:0}, the word count low byte, the word count high byte, the header ECC byte, N payload bytes, the checksum low byte and the checksum high byte.
- R5: Every ECC byte (short or long) equals `ecc_i` when `ecc_en_i` was 1 at the request, and 00h otherwise.
- R6: The checksum bytes equal `csum_i` when `csum_en_i` was 1 at the request, and 0000h otherwise. A short packet never carries checksum bytes.
- R7: A long packet with N = 0 goes straight from the header ECC byte to the footer. No payload byte is consumed (`pl_ready_o` stays low).
- R8: Payload bytes reach the output unchanged and in arrival order. During the payload phase `pl_ready_o` follows `out_ready_i`, and outside it `pl_ready_o` is 0. Exactly N bytes are taken.
- R9: `out_last_o` is 1 only with the final byte of a packet: the ECC byte of a short packet or the checksum high byte of a long packet.
- R10: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` stays high. The identifier and word-count bytes also stay unchanged.
- R11: After reset, `out_valid_o` and `pl_ready_o` are 0 and `req_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Formatter idle, request can be taken |
| vc_i | input | 2 | Virtual channel ID |
| dtype_i | input | 6 | Data type |
| len_i | input | 16 | Number of read bytes |
| short_en_i | input | 1 | Short format allowed |
| ecc_en_i | input | 1 | Send ECC bytes (else 00h) |
| csum_en_i | input | 1 | Send checksum (else 0000h) |
| ecc_i | input | 8 | Externally computed ECC byte |
| csum_i | input | 16 | Externally computed running checksum |
| pl_data_i | input | 8 | Payload byte |
| pl_valid_i | input | 1 | Payload byte valid |
| pl_ready_o | output | 1 | Payload byte accepted |
| out_data_o | output | 8 | Output byte |
| out_valid_o | output | 1 | Output byte valid |
| out_ready_i | input | 1 | Output byte accepted |
| out_last_o | output | 1 | Final byte of packet |

## Verification
The assertions check the handshake rules on every cycle. A held identifier or word-count byte does not change under backpressure. `out_last_o` never appears without valid, and the block is ready for a new request right after the last byte. Disabled ECC and checksum bytes read as zero, and `pl_ready_o` is never high outside the payload phase or without `out_ready_i`. A short packet never enters a footer state. The directed scenarios are the only way to show the full byte order of each format. They also show the choice between short and long at the 7-, 8- and 0-byte limits, the identifier packing of the count, the low-byte-first word count and checksum, and the empty long packet.

// File: rtl/rd_resp_pkg.sv
package rd_resp_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DI,
    ST_WC_LO,
    ST_WC_HI,
    ST_HECC,
    ST_PAY,
    ST_SECC,
    ST_CS_LO,
    ST_CS_HI
  } rr_state_e;
endpackage

// File: rtl/rd_resp_ctrl.sv
module rd_resp_ctrl
  import rd_resp_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             short_sel_i,
  input  logic             pl_valid_i,
  input  logic             out_ready_i,
  output logic             req_ready_o,
  output logic             take_o,
  output rr_state_e        state_o,
  output logic             out_valid_o,
  output logic             out_last_o,
  output logic             pl_ready_o
);
  rr_state_e        state_q;
  logic [LEN_W-1:0] rem_q;
  logic             short_q;

  assign req_ready_o = (state_q == ST_IDLE);
  assign take_o      = req_valid_i && req_ready_o;
  assign state_o     = state_q;
  assign out_valid_o = (state_q == ST_PAY) ? pl_valid_i : (state_q != ST_IDLE);
  assign pl_ready_o  = (state_q == ST_PAY) && out_ready_i;
  assign out_last_o  = (state_q == ST_SECC) || (state_q == ST_CS_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      short_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          short_q <= short_sel_i;
          rem_q   <= len_i;
          state_q <= ST_DI;
        end
        ST_DI:    if (out_ready_i) state_q <= short_q ? ST_PAY : ST_WC_LO;
        ST_WC_LO: if (out_ready_i) state_q <= ST_WC_HI;
        ST_WC_HI: if (out_ready_i) state_q <= ST_HECC;
        ST_HECC:  if (out_ready_i) state_q <= (rem_q == '0) ? ST_CS_LO : ST_PAY;
        ST_PAY: if (pl_valid_i && out_ready_i) begin
          rem_q <= rem_q - 1'b1;
          if (rem_q == LEN_W'(1)) state_q <= short_q ? ST_SECC : ST_CS_LO;
        end
        ST_SECC:  if (out_ready_i) state_q <= ST_IDLE;
        ST_CS_LO: if (out_ready_i) state_q <= ST_CS_HI;
        ST_CS_HI: if (out_ready_i) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  AST_PAY_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_PAY |-> rem_q != '0); // R8
  AST_SHORT_NO_FOOTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_q && state_q != ST_IDLE |-> state_q != ST_CS_LO && state_q != ST_CS_HI); // R6
  AST_PL_READY_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pl_ready_o |-> out_ready_i && state_q == ST_PAY); // R8
endmodule

// File: rtl/rd_resp_mux.sv
module rd_resp_mux
  import rd_resp_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  rr_state_e         state_i,
  input  logic [BYTE_W-1:0] di_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              ecc_en_i,
  input  logic              csum_en_i,
  input  logic [BYTE_W-1:0] ecc_i,
  input  logic [15:0]       csum_i,
  input  logic [BYTE_W-1:0] pl_data_i,
  output logic [BYTE_W-1:0] data_o
);
  logic [15:0] wc;
  logic [15:0] cs;

  assign wc = 16'(len_i);
  assign cs = csum_en_i ? csum_i : 16'h0000;

  always_comb begin
    unique case (state_i)
      ST_DI:            data_o = di_i;
      ST_WC_LO:         data_o = wc[7:0];
      ST_WC_HI:         data_o = wc[15:8];
      ST_HECC, ST_SECC: data_o = ecc_en_i ? ecc_i : 8'h00;
      ST_PAY:           data_o = pl_data_i;
      ST_CS_LO:         data_o = cs[7:0];
      ST_CS_HI:         data_o = cs[15:8];
      default:          data_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/rd_resp_fmt.sv
module rd_resp_fmt
  import rd_resp_pkg::*;
#(
  parameter int unsigned VC_W      = 2,
  parameter int unsigned DT_W      = 6,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned SHORT_MAX = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [VC_W-1:0]   vc_i,
  input  logic [DT_W-1:0]   dtype_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              short_en_i,
  input  logic              ecc_en_i,
  input  logic              csum_en_i,
  input  logic [BYTE_W-1:0] ecc_i,
  input  logic [15:0]       csum_i,
  input  logic [BYTE_W-1:0] pl_data_i,
  input  logic              pl_valid_i,
  output logic              pl_ready_o,
  output logic [BYTE_W-1:0] out_data_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              out_last_o
);
  localparam int unsigned CNT_W = $clog2(SHORT_MAX + 1);

  logic              short_sel, take;
  logic [BYTE_W-1:0] di_d, di_q;
  logic [LEN_W-1:0]  len_q;
  logic              ecc_en_q, csum_en_q;
  rr_state_e         state;

  assign short_sel = short_en_i && (len_i != '0) && (len_i <= LEN_W'(SHORT_MAX));
  // short identifier carries the byte count in its low bits
  assign di_d = short_sel ? {vc_i, dtype_i[DT_W-1:CNT_W], len_i[CNT_W-1:0]}
                          : {vc_i, dtype_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      di_q      <= '0;
      len_q     <= '0;
      ecc_en_q  <= 1'b0;
      csum_en_q <= 1'b0;
    end else if (take) begin
      di_q      <= di_d;
      len_q     <= len_i;
      ecc_en_q  <= ecc_en_i;
      csum_en_q <= csum_en_i;
    end
  end

  rd_resp_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .len_i      (len_i),
    .short_sel_i(short_sel),
    .pl_valid_i (pl_valid_i),
    .out_ready_i(out_ready_i),
    .req_ready_o(req_ready_o),
    .take_o     (take),
    .state_o    (state),
    .out_valid_o(out_valid_o),
    .out_last_o (out_last_o),
    .pl_ready_o (pl_ready_o)
  );

  rd_resp_mux #(.LEN_W(LEN_W)) u_mux (
    .state_i  (state),
    .di_i     (di_q),
    .len_i    (len_q),
    .ecc_en_i (ecc_en_q),
    .csum_en_i(csum_en_q),
    .ecc_i    (ecc_i),
    .csum_i   (csum_i),
    .pl_data_i(pl_data_i),
    .data_o   (out_data_o)
  );

  AST_REQ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !out_valid_o); // R1
  AST_HOLD_HEADER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i && (state == ST_DI || state == ST_WC_LO || state == ST_WC_HI)
    |=> out_valid_o && $stable(out_data_o)); // R10
  AST_LAST_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> out_valid_o); // R9
  AST_END_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && out_last_o |=> req_ready_o); // R9
  AST_ECC_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && (state == ST_HECC || state == ST_SECC) && !ecc_en_q |-> out_data_o == 8'h00); // R5
  AST_CSUM_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && (state == ST_CS_LO || state == ST_CS_HI) && !csum_en_q |-> out_data_o == 8'h00); // R6
endmodule

// File: tb/rd_resp_fmt_tb.sv
module rd_resp_fmt_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  vc = '0;
  logic [5:0]  dtype = '0;
  logic [15:0] len = '0;
  logic        short_en = 1'b0, ecc_en = 1'b0, csum_en = 1'b0;
  logic [7:0]  ecc = '0;
  logic [15:0] csum = '0;
  logic [7:0]  pl_data = '0;
  logic        pl_valid = 1'b0;
  logic        pl_ready;
  logic [7:0]  out_data;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic        out_last;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  rd_resp_fmt u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .vc_i(vc), .dtype_i(dtype), .len_i(len),
    .short_en_i(short_en), .ecc_en_i(ecc_en), .csum_en_i(csum_en),
    .ecc_i(ecc), .csum_i(csum),
    .pl_data_i(pl_data), .pl_valid_i(pl_valid), .pl_ready_o(pl_ready),
    .out_data_o(out_data), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .out_last_o(out_last)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_pkt(input string req, input logic [1:0] t_vc, input logic [5:0] t_dt,
                         input int n, input bit t_sen, input bit t_een, input bit t_cen,
                         input logic [7:0] t_ecc, input logic [15:0] t_cs, input int stall_mod);
    logic [7:0] pay[$];
    logic [7:0] exp_q[$];
    logic [7:0] got_q[$];
    bit short_f;
    int taken = 0;
    bit pl_seen = 0;
    for (int i = 0; i < n; i++) pay.push_back(8'((n * 7 + i * 13 + 5) & 255));
    short_f = t_sen && n >= 1 && n <= 7;
    if (short_f) begin
      exp_q.push_back({t_vc, t_dt[5:3], 3'(n)});
      foreach (pay[i]) exp_q.push_back(pay[i]);
      exp_q.push_back(t_een ? t_ecc : 8'h00);
    end else begin
      exp_q.push_back({t_vc, t_dt});
      exp_q.push_back(8'(n & 255));
      exp_q.push_back(8'((n >> 8) & 255));
      exp_q.push_back(t_een ? t_ecc : 8'h00);
      foreach (pay[i]) exp_q.push_back(pay[i]);
      exp_q.push_back(t_cen ? t_cs[7:0] : 8'h00);
      exp_q.push_back(t_cen ? t_cs[15:8] : 8'h00);
    end

    @(negedge clk);
    vc = t_vc; dtype = t_dt; len = 16'(n); short_en = t_sen;
    ecc_en = t_een; csum_en = t_cen; ecc = t_ecc; csum = t_cs;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R1", "req_ready while busy", int'(req_ready), 0);

    fork
      begin : drv
        int c = 0;
        bit acc = 0;
        while (taken < n) begin
          @(negedge clk);
          c++;
          if (acc) begin pl_valid = 1'b0; acc = 0; end
          if (!pl_valid && (c % 3 != 1)) begin pl_valid = 1'b1; pl_data = pay[taken]; end
          #1;
          if (pl_valid && pl_ready) begin acc = 1; taken++; end
        end
        @(negedge clk);
        pl_valid = 1'b0;
      end
      begin : col
        int c2 = 0;
        bit done = 0;
        bit stall = 0;
        logic [7:0] held = '0;
        while (!done && c2 < 3000) begin
          @(negedge clk);
          c2++;
          out_ready = (stall_mod == 0) || (c2 % stall_mod != 0);
          #1;
          if (pl_ready) pl_seen = 1;
          if (stall) begin
            chk(out_valid && out_data == held, "R10", "byte held under backpressure", int'(out_data), int'(held));
          end
          stall = 0;
          if (out_valid) begin
            if (out_ready) begin
              got_q.push_back(out_data);
              chk(out_last == (got_q.size() == exp_q.size()), "R9", "last marker position",
                  int'(out_last), int'(got_q.size() == exp_q.size()));
              if (out_last) done = 1;
            end else begin
              stall = 1;
              held = out_data;
            end
          end
        end
        @(negedge clk);
        out_ready = 1'b0;
      end
    join

    chk(got_q.size() == exp_q.size(), req, "packet length", got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk(got_q[i] == exp_q[i], req, $sformatf("byte %0d", i), int'(got_q[i]), int'(exp_q[i]));
    chk(taken == n, "R8", "payload bytes consumed", taken, n);
    if (n == 0) chk(!pl_seen, "R7", "pl_ready during empty packet", int'(pl_seen), 0);
    chk(req_ready == 1'b1, "R1", "ready after packet", int'(req_ready), 1);
  endtask

  task automatic t_reset();
    #1;
    chk(out_valid == 1'b0, "R11", "out_valid in reset", int'(out_valid), 0);
    chk(pl_ready == 1'b0, "R11", "pl_ready in reset", int'(pl_ready), 0);
    chk(req_ready == 1'b1, "R11", "req_ready in reset", int'(req_ready), 1);
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog expired: actual=1 expected=0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    // R2 R3 R5: short, 3 bytes, ECC on
    run_pkt("R2 R3 R5", 2'd1, 6'h21, 3, 1, 1, 1, 8'h5A, 16'hBEEF, 0);
    // R5 R6: short, 7 bytes, ECC off, no footer though checksum enabled
    run_pkt("R5 R6", 2'd3, 6'h3F, 7, 1, 0, 1, 8'hA7, 16'h1234, 3);
    // R4 R6 R8: long, 10 bytes, backpressure
    run_pkt("R4 R6 R8", 2'd2, 6'h1C, 10, 0, 1, 1, 8'h3C, 16'hC0DE, 4);
    // R2: 8 bytes with short allowed -> long
    run_pkt("R2 R4", 2'd0, 6'h1A, 8, 1, 1, 0, 8'h77, 16'hFFFF, 2);
    // R2: 2 bytes with short not allowed -> long
    run_pkt("R2 R4", 2'd1, 6'h24, 2, 0, 0, 1, 8'h11, 16'h8001, 0);
    // R7: empty long, short allowed, checksum off
    run_pkt("R7 R6", 2'd3, 6'h1A, 0, 1, 1, 0, 8'hE1, 16'h5555, 2);
    // R4: word count high byte non-zero
    run_pkt("R4", 2'd2, 6'h1C, 300, 0, 1, 1, 8'h42, 16'h0F0F, 5);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule